// File: doc/BRIEF.md
# Set-Associative Cache Tag Profiler

This block is a tag-only cache model placed beside a memory access stream to measure how a cache of a chosen shape would behave. Each access carries an address, a byte count and a direction flag. The block looks the line up in a tag array that keeps a valid flag and a dirty flag per entry. A hit on a write marks the line dirty. A miss replaces a way picked by a pseudo-random shift register. The block keeps no data, has no backing memory and models no refill delay.

Seven 64-bit statistics are kept: read accesses, read misses, read bytes, write accesses, write misses, write bytes and dirty evictions. A plain select input picks one of them onto a read-only output.

The access input is a valid/ready stream. `acc_ready` is held high at all times, so the profiler never applies back-pressure: every cycle with `acc_valid` high is one access, and a cycle with `acc_valid` low is no access.

Top module: `cache_tag_profiler`

## Requirements
- R1: `SETS` and `LINE_BYTES` must both be nonzero powers of two; any other value stops elaboration with an error. The line address is `acc_addr >> log2(LINE_BYTES)`, so all bytes of one line share an entry.
- R2: The set index is the line address modulo `SETS`. The stored tag is the whole line address, so two lines that share a set and the low tag bits still count as different lines.
- R3: An access hits when some way of its set holds its line address with the valid flag set. The dirty flag plays no part in the comparison.
- R4: A write hit sets the dirty flag of the matching way. A read hit leaves that entry unchanged.
- R5: On a miss, the way replaced is the shift register's next value modulo `WAYS`. It is replaced even if another way of the set is invalid. The new entry is valid and clean, also when a write caused the miss.
- R6: The eviction counter goes up by one only on a miss whose replaced entry was both valid and dirty.
- R7: Each direction has its own access, miss and byte counter. Every access adds its `acc_len` to the byte counter of its direction. The new values show on the read port from the cycle after the access.
- R8: The replacement register is 16 bits wide and seeded with 0xACE1. On each miss, and only then, it shifts right by one, and the result is XORed with 0xB400 if the bit shifted out was 1. The value it steps to selects the victim.
- R9: Reset (active-low, asynchronous) clears every counter to zero, marks every entry invalid and reloads the seed.
- R10: `acc_ready` is always 1. A cycle with `acc_valid` low changes no counter and no entry, whatever the other access inputs hold.
- R11: `cnt_sel` selects the output as follows: 0 read accesses, 1 read misses, 2 read bytes, 3 write accesses, 4 write misses, 5 write bytes, 6 dirty evictions, 7 always zero. The read path is combinational, so a read in the same cycle as an update shows the value from before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_ready | output | 1 | Always high; the profiler takes one access per cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_len | input | LEN_W | Bytes moved by the access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| cnt_sel | input | 3 | Selects the statistic shown on `cnt_data` |
| cnt_data | output | CNT_W | Selected statistic |

## Verification
On a miss to a set whose victim is dirty, the dirty eviction and the install of the new line fall in the same cycle. The bench provokes this with a write hit followed by a conflicting read, and works out the victim from its own model of the shift-register sequence. It judges the case by a rise of one in the eviction counter together with a clean entry: a later miss that evicts the same line must not count again. In the second overlap, a statistic is read in the very cycle that updates it. The bench samples the port before the edge and expects the old value, then samples after the edge and expects the new one.

// File: rtl/cprof_pkg.sv
package cprof_pkg;

  typedef enum logic [2:0] {
    SEL_RD_ACC   = 3'd0,
    SEL_RD_MISS  = 3'd1,
    SEL_RD_BYTES = 3'd2,
    SEL_WR_ACC   = 3'd3,
    SEL_WR_MISS  = 3'd4,
    SEL_WR_BYTES = 3'd5,
    SEL_WBACK    = 3'd6,
    SEL_NONE     = 3'd7
  } stat_sel_e;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cprof_lfsr.sv
module cprof_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] next_val
);

  logic [W-1:0] state_q;

  always_comb begin
    next_val = state_q >> 1;
    if (state_q[0]) next_val = next_val ^ TAPS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= SEED;
    else if (step) state_q <= next_val;
  end

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q));

endmodule

// File: rtl/cprof_tags.sv
module cprof_tags #(
  parameter int unsigned SETS   = 64,
  parameter int unsigned WAYS   = 4,
  parameter int unsigned LINE_W = 26,
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_wr,
  input  logic [LINE_W-1:0] line,
  input  logic [WAY_W-1:0]  victim,
  output logic              hit,
  output logic              dirty_evict
);

  typedef struct packed {
    logic              valid;
    logic              dirty;
    logic [LINE_W-1:0] line;
  } ent_t;

  ent_t              tab_q [SETS][WAYS];
  logic [IDX_W-1:0]  idx;
  logic [WAY_W-1:0]  hway;
  ent_t              hit_ent;
  ent_t              vic_ent;

  assign idx = IDX_W'(line % LINE_W'(SETS));

  always_comb begin
    hit  = 1'b0;
    hway = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (!hit && tab_q[idx][w].valid && tab_q[idx][w].line == line) begin
        hit  = 1'b1;
        hway = WAY_W'(w);
      end
    end
  end

  assign hit_ent     = tab_q[idx][hway];
  assign vic_ent     = tab_q[idx][victim];
  assign dirty_evict = fire && !hit && vic_ent.valid && vic_ent.dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SETS); s++)
        for (int w = 0; w < int'(WAYS); w++)
          tab_q[s][w] <= '0;
    end else if (fire) begin
      if (hit) begin
        if (is_wr) tab_q[idx][hway].dirty <= 1'b1;
      end else begin
        tab_q[idx][victim] <= '{valid: 1'b1, dirty: 1'b0, line: line};
      end
    end
  end

  // R5
  fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hit) |=> (tab_q[$past(idx)][$past(victim)].valid &&
                        !tab_q[$past(idx)][$past(victim)].dirty &&
                        tab_q[$past(idx)][$past(victim)].line == $past(line)));

  // R4
  wr_hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit && is_wr) |=> tab_q[$past(idx)][$past(hway)].dirty);

  // R4
  rd_hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit && !is_wr) |=> tab_q[$past(idx)][$past(hway)] == $past(hit_ent));

endmodule

// File: rtl/cprof_stats.sv
module cprof_stats #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             is_wr,
  input  logic [LEN_W-1:0] len,
  input  logic             miss,
  input  logic             dirty_evict,
  input  logic [2:0]       sel,
  output logic [CNT_W-1:0] data
);
  import cprof_pkg::*;

  logic [CNT_W-1:0] rd_acc_q, rd_miss_q, rd_bytes_q;
  logic [CNT_W-1:0] wr_acc_q, wr_miss_q, wr_bytes_q;
  logic [CNT_W-1:0] wback_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_acc_q   <= '0;
      rd_miss_q  <= '0;
      rd_bytes_q <= '0;
      wr_acc_q   <= '0;
      wr_miss_q  <= '0;
      wr_bytes_q <= '0;
      wback_q    <= '0;
    end else if (fire) begin
      if (is_wr) begin
        wr_acc_q   <= wr_acc_q + 1'b1;
        wr_bytes_q <= wr_bytes_q + CNT_W'(len);
        if (miss) wr_miss_q <= wr_miss_q + 1'b1;
      end else begin
        rd_acc_q   <= rd_acc_q + 1'b1;
        rd_bytes_q <= rd_bytes_q + CNT_W'(len);
        if (miss) rd_miss_q <= rd_miss_q + 1'b1;
      end
      if (dirty_evict) wback_q <= wback_q + 1'b1;
    end
  end

  always_comb begin
    case (stat_sel_e'(sel))
      SEL_RD_ACC:   data = rd_acc_q;
      SEL_RD_MISS:  data = rd_miss_q;
      SEL_RD_BYTES: data = rd_bytes_q;
      SEL_WR_ACC:   data = wr_acc_q;
      SEL_WR_MISS:  data = wr_miss_q;
      SEL_WR_BYTES: data = wr_bytes_q;
      SEL_WBACK:    data = wback_q;
      default:      data = '0;
    endcase
  end

  // R7
  rd_acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !is_wr) |=> (rd_acc_q == $past(rd_acc_q) + 1'b1) && $stable(wr_acc_q));

  // R6
  wback_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !miss) |=> $stable(wback_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(rd_bytes_q) && $stable(wr_bytes_q) && $stable(wback_q)));

endmodule

// File: rtl/cache_tag_profiler.sv
module cache_tag_profiler #(
  parameter int unsigned SETS       = 64,
  parameter int unsigned WAYS       = 4,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned CNT_W      = 64,
  localparam int unsigned OFF_W     = (LINE_BYTES > 1) ? $clog2(LINE_BYTES) : 0,
  localparam int unsigned LINE_W    = ADDR_W - OFF_W,
  localparam int unsigned WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned RND_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic              acc_write,
  input  logic [2:0]        cnt_sel,
  output logic [CNT_W-1:0]  cnt_data
);

  // R1: shape checks at elaboration
  if (!cprof_pkg::is_pow2(SETS)) begin : g_bad_sets
    $error("cache_tag_profiler: SETS must be a nonzero power of two");
  end
  if (!cprof_pkg::is_pow2(LINE_BYTES)) begin : g_bad_line
    $error("cache_tag_profiler: LINE_BYTES must be a nonzero power of two");
  end

  logic              fire;
  logic [LINE_W-1:0] line;
  logic              hit;
  logic              dirty_evict;
  logic [RND_W-1:0]  rnd_next;
  logic [WAY_W-1:0]  victim;

  assign acc_ready = 1'b1;
  assign fire      = acc_valid && acc_ready;
  assign line      = acc_addr[ADDR_W-1:OFF_W];
  assign victim    = WAY_W'(rnd_next % RND_W'(WAYS));

  cprof_lfsr #(
    .W    (RND_W),
    .SEED (16'hACE1),
    .TAPS (16'hB400)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (fire && !hit),
    .next_val (rnd_next)
  );

  cprof_tags #(
    .SETS   (SETS),
    .WAYS   (WAYS),
    .LINE_W (LINE_W)
  ) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .is_wr       (acc_write),
    .line        (line),
    .victim      (victim),
    .hit         (hit),
    .dirty_evict (dirty_evict)
  );

  cprof_stats #(
    .CNT_W (CNT_W),
    .LEN_W (LEN_W)
  ) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .is_wr       (acc_write),
    .len         (acc_len),
    .miss        (!hit),
    .dirty_evict (dirty_evict),
    .sel         (cnt_sel),
    .data        (cnt_data)
  );

  // R6
  evict_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_evict |-> (fire && !hit));

endmodule

// File: tb/test_cache_tag_profiler.sv
module test_cache_tag_profiler;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned LEN_W  = 8;
  localparam int unsigned CNT_W  = 64;
  localparam int NV = 17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acc_valid = 1'b0;
  logic              acc_ready;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [LEN_W-1:0]  acc_len = '0;
  logic              acc_write = 1'b0;
  logic [2:0]        cnt_sel = '0;
  logic [CNT_W-1:0]  cnt_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  cache_tag_profiler #(
    .SETS(4), .WAYS(2), .LINE_BYTES(16),
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) i_cache_tag_profiler (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_len(acc_len), .acc_write(acc_write),
    .cnt_sel(cnt_sel), .cnt_data(cnt_data)
  );

  // Vector: {write, addr[31:0], len[7:0], exp_miss, exp_wb}
  // Geometry 4 sets x 2 ways x 16 bytes; victim way = LFSR step k (k-th miss) mod 2:
  // steps E270,7138,389C,1C4E,0E27,B313,ED89,C2C4,6162,30B1 -> 0,0,0,0,1,1,1,0,0,1
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 32'h000, 8'd4, 1'b1, 1'b0},  // miss, way0 <- L0
    {1'b0, 32'h004, 8'd2, 1'b0, 1'b0},  // hit same line (R1)
    {1'b1, 32'h008, 8'd4, 1'b0, 1'b0},  // write hit, dirty
    {1'b0, 32'h040, 8'd4, 1'b1, 1'b1},  // L4 evicts dirty L0
    {1'b0, 32'h000, 8'd4, 1'b1, 1'b0},  // L0 evicts clean L4
    {1'b1, 32'h100, 8'd8, 1'b1, 1'b0},  // write miss installs clean L16
    {1'b1, 32'h100, 8'd8, 1'b0, 1'b0},  // write hit, dirty
    {1'b0, 32'h010, 8'd4, 1'b1, 1'b0},  // set1 way1 <- L1
    {1'b1, 32'h014, 8'd4, 1'b0, 1'b0},  // dirty L1
    {1'b0, 32'h050, 8'd1, 1'b1, 1'b1},  // L5 evicts dirty L1
    {1'b1, 32'h200, 8'd2, 1'b1, 1'b0},  // set0 way1 <- L32 (was invalid)
    {1'b0, 32'h108, 8'd4, 1'b0, 1'b0},  // hit dirty L16
    {1'b1, 32'h204, 8'd4, 1'b0, 1'b0},  // dirty L32
    {1'b0, 32'h300, 8'd4, 1'b1, 1'b1},  // L48 evicts dirty L16
    {1'b0, 32'h200, 8'd4, 1'b0, 1'b0},  // hit dirty L32 (R3)
    {1'b1, 32'h400, 8'd2, 1'b1, 1'b0},  // L64 evicts clean L48
    {1'b0, 32'h000, 8'd4, 1'b1, 1'b1}   // L0 evicts dirty L32
  };

  logic [63:0] m [7];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_all(input string req);
    for (int s = 0; s < 7; s++) begin
      cnt_sel = 3'(s);
      #1;
      chk(req, cnt_data, m[s]);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 7; s++) m[s] = '0;
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [7:0] l);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_len = l;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    // R9: reset state
    read_all("R9 reset");
    cnt_sel = 3'd7; #1;
    chk("R11 sel7", cnt_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: ready held high
    chk("R10 ready", {63'd0, acc_ready}, 64'd1);

    // Main table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic        wr;
      logic [7:0]  ln;
      logic        ms, wb;
      wr = VEC[i][42]; ln = VEC[i][9:2]; ms = VEC[i][1]; wb = VEC[i][0];
      access(wr, VEC[i][41:10], ln);
      if (wr) begin
        m[3]++; m[5] += 64'(ln); if (ms) m[4]++;
      end else begin
        m[0]++; m[2] += 64'(ln); if (ms) m[1]++;
      end
      if (wb) m[6]++;
      read_all($sformatf("R2-vec%0d R5 R6 R7", i));
    end

    // R10: idle cycles with busy-looking inputs change nothing
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 32'h000; acc_len = 8'd200;
    repeat (3) @(negedge clk);
    read_all("R10 idle");

    // R11: same-cycle read shows old value, then new value
    @(negedge clk);
    cnt_sel = 3'd5;
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 32'h000; acc_len = 8'd7;
    #1;
    chk("R11 before edge", cnt_data, m[5]);
    @(negedge clk);
    acc_valid = 1'b0;
    m[3]++; m[5] += 64'd7;  // L0 present in set0 way1: write hit
    #1;
    chk("R11 after edge", cnt_data, m[5]);
    read_all("R4 write hit on resident line");

    // R9: reset mid-run, then table restarts from seed
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    clear_model();
    read_all("R9 mid-run reset");
    rst_n = 1'b1;
    // first miss -> way0, write miss installs clean L0; read of L4 (step 2 -> way0) evicts
    // clean L0: no eviction count (R5 clean install, R8 seed reload)
    access(1'b1, 32'h000, 8'd4);
    access(1'b0, 32'h040, 8'd4);
    m[3] = 1; m[5] = 4; m[4] = 1; m[0] = 1; m[2] = 4; m[1] = 1; m[6] = 0;
    read_all("R5 R8 after reset");
    // back-to-back accesses: same line three times, one cycle each
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h044; acc_len = 8'd3;
    @(negedge clk);
    acc_write = 1'b1;
    @(negedge clk);
    acc_write = 1'b0; acc_addr = 32'h048;
    @(negedge clk);
    acc_valid = 1'b0;
    m[0] += 2; m[2] += 6; m[3] += 1; m[5] += 3;
    read_all("R7 back-to-back hits");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule